// File: doc/BRIEF.md
# Address Breakpoint Debug Unit

This block watches two address streams of a processor, the instruction fetch address and the load/store address, against a small set of programmable breakpoints. Some breakpoints compare against fetches and the others against data accesses. Each breakpoint holds an address value, a mask and a control field. A mask bit of 1 makes the address bit in that position a don't-care. When an armed breakpoint matches and the status bits allow it, the unit raises a trap request one cycle later. The request carries an interruption number and the address that caused it.

Instruction breakpoints fire on any fetch at a matching address, including nullified ones. Data breakpoints fire only on non-nullified accesses, and the access type must agree with the read and write enables of the breakpoint. The global status bit gates both kinds of trap. Two one-shot status bits each suppress one kind. Software reaches the registers through a plain select/write/read port. While the unit enable bit is low, every access on that port is refused and flagged as an emulation trap.

Top module: `addr_bkpt_unit`

## Requirements
- R1: After reset `trap_req` is 0, and every register of every breakpoint reads back as 0, so all breakpoints start disarmed.
- R2: `cfg_sel` is {breakpoint index, field}. Indices 0..NUM_IBP-1 are instruction breakpoints and the following NUM_DBP indices are data breakpoints. Field 0 is the address, 1 the mask, 2 the control word and 3 is reserved. A field-3 read returns 0, and a field-3 write changes nothing. A write takes effect at the clock edge when `cfg_valid`, `cfg_write` and `unit_en` are all 1. A read is combinational and returns data when `cfg_valid` is 1 and `cfg_write` is 0. At all other times `cfg_rdata` is 0.
- R3: In the control word, bit 0 is the enable of an instruction breakpoint, and its bit 1 always reads 0. For a data breakpoint, bit 0 is the read enable and bit 1 the write enable.
- R4: When `unit_en` is 0, every port access raises `cfg_emu_trap` in the same cycle, a write is ignored, and a read returns 0.
- R5: A breakpoint matches when ((address XOR register) AND NOT mask) is 0.
- R6: A fetch that matches an enabled instruction breakpoint, nullified or not, gives `trap_req`=1 in the next cycle with `trap_num`=30 and `trap_addr` equal to the fetch address. This requires `stat_g`=1 and `stat_z`=0.
- R7: A non-nullified data access that matches a data breakpoint gives `trap_req`=1 in the next cycle with `trap_num`=31 and `trap_addr` equal to the access address. This requires `stat_g`=1 and `stat_y`=0, and the access kind must be allowed. The `mem_kind` codes are 0 load, 1 store, 2 semaphore and 3 cache purge. The read enable allows kinds 0 and 2, and the write enable allows kinds 1, 2 and 3. A nullified access never traps.
- R8: `stat_g`=0 blocks every trap. `stat_y`=1 blocks only data traps, and `stat_z`=1 blocks only instruction traps.
- R9: When an instruction trap and a data trap arise from the same cycle, the instruction trap is reported (number 30, fetch address).
- R10: Several breakpoints of the same kind matching in one cycle give a single one-cycle request. `trap_req` returns to 0 after a cycle with no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Debug unit enable; 0 refuses port accesses |
| stat_g | input | 1 | Global debug trap enable |
| stat_y | input | 1 | Data trap suppress |
| stat_z | input | 1 | Instruction trap suppress |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_nullified | input | 1 | Fetched instruction is nullified (does not block) |
| mem_valid | input | 1 | A data access is presented this cycle |
| mem_addr | input | ADDR_W | Data access address |
| mem_kind | input | 2 | 0 load, 1 store, 2 semaphore, 3 cache purge |
| mem_nullified | input | 1 | Data access is nullified |
| cfg_valid | input | 1 | Register port access this cycle |
| cfg_write | input | 1 | 1 write, 0 read |
| cfg_sel | input | IDX_W+2 | {breakpoint index, field} |
| cfg_wdata | input | ADDR_W | Write data |
| cfg_rdata | output | ADDR_W | Read data (combinational) |
| cfg_emu_trap | output | 1 | Access refused because the unit is off |
| trap_req | output | 1 | Debug trap request |
| trap_num | output | 5 | Interruption number, 30 or 31 |
| trap_addr | output | ADDR_W | Captured trapping address |

## Verification
The bench builds the unit with an 8-bit address and the default count of two instruction and two data breakpoints. With this configuration it can sweep every fetch address and every data address, under each access kind and both nullify values, against masks that open and close whole groups of bits. It computes the match rule arithmetically for each point. The narrow width also leaves room for sweeps under each setting of the status bits, and for direct cases of overlapping breakpoints and of instruction and data traps in the same cycle.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   localparam int TRAP_NUM_W = 5;
   localparam logic [TRAP_NUM_W-1:0] ITRAP_NUM = 5'd30;
   localparam logic [TRAP_NUM_W-1:0] DTRAP_NUM = 5'd31;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_SEMA  = 2'd2,
      ACC_PURGE = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      FLD_ADDR = 2'd0,
      FLD_MASK = 2'd1,
      FLD_CTRL = 2'd2,
      FLD_RSVD = 2'd3
   } bp_fld_e;
endpackage

// File: rtl/bkpt_cmp.sv
module bkpt_cmp #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] probe,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [ADDR_W-1:0] dont_care,
   output logic              hit
);
   // masked equality: bits set in dont_care never disqualify
   assign hit = ~|((probe ^ ref_addr) & ~dont_care);
endmodule

// File: rtl/bkpt_regs.sv
module bkpt_regs
   import bkpt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_IBP = 2,
   parameter int NUM_BP  = 4,
   parameter int SEL_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] addr_q [NUM_BP],
   output logic [ADDR_W-1:0] mask_q [NUM_BP],
   output logic [1:0]        ctrl_q [NUM_BP],
   output logic [ADDR_W-1:0] rd_data
);
   localparam int IDX_W = SEL_W - 2;

   logic [IDX_W-1:0] idx;
   bp_fld_e          fld;

   assign idx = sel[SEL_W-1:2];
   assign fld = bp_fld_e'(sel[1:0]);

   for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
      // instruction slots keep only the enable bit
      localparam logic [1:0] CTRL_KEEP = (b < NUM_IBP) ? 2'b01 : 2'b11;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_q[b] <= '0;
            mask_q[b] <= '0;
            ctrl_q[b] <= '0;
         end else if (wr_en && idx == IDX_W'(b)) begin
            case (fld)
               FLD_ADDR: addr_q[b] <= wdata;
               FLD_MASK: mask_q[b] <= wdata;
               FLD_CTRL: ctrl_q[b] <= wdata[1:0] & CTRL_KEEP;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (int'(idx) < NUM_BP) begin
         case (fld)
            FLD_ADDR: rd_data = addr_q[idx];
            FLD_MASK: rd_data = mask_q[idx];
            FLD_CTRL: rd_data = {{(ADDR_W-2){1'b0}}, ctrl_q[idx]};
            default:  rd_data = '0;
         endcase
      end
   end
endmodule

// File: rtl/bkpt_trap.sv
module bkpt_trap
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  i_fire,
   input  logic [ADDR_W-1:0]     i_addr,
   input  logic                  d_fire,
   input  logic [ADDR_W-1:0]     d_addr,
   output logic                  trap_req,
   output logic [TRAP_NUM_W-1:0] trap_num,
   output logic [ADDR_W-1:0]     trap_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_req  <= 1'b0;
         trap_num  <= '0;
         trap_addr <= '0;
      end else begin
         trap_req <= i_fire | d_fire;
         // lower interruption number wins
         if (i_fire) begin
            trap_num  <= ITRAP_NUM;
            trap_addr <= i_addr;
         end else if (d_fire) begin
            trap_num  <= DTRAP_NUM;
            trap_addr <= d_addr;
         end
      end
   end
endmodule

// File: rtl/addr_bkpt_unit.sv
module addr_bkpt_unit
   import bkpt_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_IBP = 2,
   parameter int NUM_DBP = 2,
   localparam int NUM_BP = NUM_IBP + NUM_DBP,
   localparam int IDX_W  = $clog2(NUM_BP),
   localparam int SEL_W  = IDX_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  unit_en,
   input  logic                  stat_g,
   input  logic                  stat_y,
   input  logic                  stat_z,
   input  logic                  fetch_valid,
   input  logic [ADDR_W-1:0]     fetch_addr,
   input  logic                  fetch_nullified,
   input  logic                  mem_valid,
   input  logic [ADDR_W-1:0]     mem_addr,
   input  logic [1:0]            mem_kind,
   input  logic                  mem_nullified,
   input  logic                  cfg_valid,
   input  logic                  cfg_write,
   input  logic [SEL_W-1:0]      cfg_sel,
   input  logic [ADDR_W-1:0]     cfg_wdata,
   output logic [ADDR_W-1:0]     cfg_rdata,
   output logic                  cfg_emu_trap,
   output logic                  trap_req,
   output logic [TRAP_NUM_W-1:0] trap_num,
   output logic [ADDR_W-1:0]     trap_addr
);
   localparam int SLOT_W = 2 * ADDR_W + 2;
   localparam int IMG_W  = NUM_BP * SLOT_W;

   if (ADDR_W < 2) begin : g_chk_w
      $error("addr_bkpt_unit: ADDR_W must be at least 2");
   end
   if (NUM_IBP < 1 || NUM_DBP < 1) begin : g_chk_n
      $error("addr_bkpt_unit: need at least one breakpoint of each kind");
   end

   logic [ADDR_W-1:0] addr_q [NUM_BP];
   logic [ADDR_W-1:0] mask_q [NUM_BP];
   logic [1:0]        ctrl_q [NUM_BP];
   logic [ADDR_W-1:0] rd_raw;
   logic              wr_en;

   // fetch fields are used regardless of nullify; reference it to keep intent explicit
   logic fetch_null_unused;
   assign fetch_null_unused = fetch_nullified;

   assign wr_en        = cfg_valid & cfg_write & unit_en;
   assign cfg_emu_trap = cfg_valid & ~unit_en;
   assign cfg_rdata    = (cfg_valid & ~cfg_write & unit_en) ? rd_raw : '0;

   bkpt_regs #(
      .ADDR_W (ADDR_W),
      .NUM_IBP(NUM_IBP),
      .NUM_BP (NUM_BP),
      .SEL_W  (SEL_W)
   ) regs_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .addr_q (addr_q),
      .mask_q (mask_q),
      .ctrl_q (ctrl_q),
      .rd_data(rd_raw)
   );

   logic [NUM_IBP-1:0] i_hit;
   logic [NUM_DBP-1:0] d_hit;
   logic               kind_rd, kind_wr;

   assign kind_rd = (mem_kind == ACC_LOAD) || (mem_kind == ACC_SEMA);
   assign kind_wr = (mem_kind != ACC_LOAD);

   for (genvar i = 0; i < NUM_IBP; i++) begin : g_ibp
      logic raw;
      bkpt_cmp #(.ADDR_W(ADDR_W)) cmp_i (
         .probe    (fetch_addr),
         .ref_addr (addr_q[i]),
         .dont_care(mask_q[i]),
         .hit      (raw)
      );
      assign i_hit[i] = raw & ctrl_q[i][0];
   end

   for (genvar d = 0; d < NUM_DBP; d++) begin : g_dbp
      localparam int S = NUM_IBP + d;
      logic raw;
      bkpt_cmp #(.ADDR_W(ADDR_W)) cmp_i (
         .probe    (mem_addr),
         .ref_addr (addr_q[S]),
         .dont_care(mask_q[S]),
         .hit      (raw)
      );
      assign d_hit[d] = raw & ((ctrl_q[S][0] & kind_rd) | (ctrl_q[S][1] & kind_wr));
   end

   logic i_fire, d_fire;
   assign i_fire = fetch_valid & stat_g & ~stat_z & (|i_hit);
   assign d_fire = mem_valid & ~mem_nullified & stat_g & ~stat_y & (|d_hit);

   bkpt_trap #(.ADDR_W(ADDR_W)) trap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .i_fire   (i_fire),
      .i_addr   (fetch_addr),
      .d_fire   (d_fire),
      .d_addr   (mem_addr),
      .trap_req (trap_req),
      .trap_num (trap_num),
      .trap_addr(trap_addr)
   );

   // flattened register image for the bound checker
   logic [IMG_W-1:0] reg_image;
   for (genvar b = 0; b < NUM_BP; b++) begin : g_img
      assign reg_image[b*SLOT_W +: SLOT_W] = {addr_q[b], mask_q[b], ctrl_q[b]};
   end
endmodule

// File: rtl/bkpt_chk.sv
module bkpt_chk
   import bkpt_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMG_W  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  unit_en,
   input logic                  stat_g,
   input logic                  stat_y,
   input logic                  stat_z,
   input logic                  fetch_valid,
   input logic [ADDR_W-1:0]     fetch_addr,
   input logic                  mem_valid,
   input logic                  mem_nullified,
   input logic                  cfg_valid,
   input logic                  cfg_write,
   input logic                  trap_req,
   input logic [TRAP_NUM_W-1:0] trap_num,
   input logic [ADDR_W-1:0]     trap_addr,
   input logic [IMG_W-1:0]      reg_image
);
   a_r4_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && cfg_write && !unit_en) |=> $stable(reg_image));

   a_r6_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (trap_num == ITRAP_NUM || trap_num == DTRAP_NUM));

   a_r6_fetch_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && trap_num == ITRAP_NUM) |-> trap_addr == $past(fetch_addr));

   a_r7_data_source: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req && trap_num == DTRAP_NUM) |-> $past(mem_valid && !mem_nullified && !stat_y));

   a_r8_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_g |=> !trap_req);

   a_r8_z_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_z && !mem_valid) |=> !trap_req);

   a_r8_y_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_y && !fetch_valid) |=> !trap_req);

   a_r7_nullified_data: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_nullified && !fetch_valid) |=> !trap_req);
endmodule

bind addr_bkpt_unit bkpt_chk #(.ADDR_W(ADDR_W), .IMG_W(IMG_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .unit_en      (unit_en),
   .stat_g       (stat_g),
   .stat_y       (stat_y),
   .stat_z       (stat_z),
   .fetch_valid  (fetch_valid),
   .fetch_addr   (fetch_addr),
   .mem_valid    (mem_valid),
   .mem_nullified(mem_nullified),
   .cfg_valid    (cfg_valid),
   .cfg_write    (cfg_write),
   .trap_req     (trap_req),
   .trap_num     (trap_num),
   .trap_addr    (trap_addr),
   .reg_image    (reg_image)
);

// File: tb/addr_bkpt_unit_tb_top.sv
`timescale 1ns/1ps
module addr_bkpt_unit_tb_top;
   localparam int AW = 8;
   localparam int SW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          unit_en = 1'b0;
   logic          stat_g = 1'b0, stat_y = 1'b0, stat_z = 1'b0;
   logic          fetch_valid = 1'b0, fetch_nullified = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic          mem_valid = 1'b0, mem_nullified = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [1:0]    mem_kind = '0;
   logic          cfg_valid = 1'b0, cfg_write = 1'b0;
   logic [SW-1:0] cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic [AW-1:0] cfg_rdata;
   logic          cfg_emu_trap;
   logic          trap_req;
   logic [4:0]    trap_num;
   logic [AW-1:0] trap_addr;

   always #2.5 clk = ~clk;

   addr_bkpt_unit #(.ADDR_W(AW), .NUM_IBP(2), .NUM_DBP(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .unit_en(unit_en),
      .stat_g(stat_g), .stat_y(stat_y), .stat_z(stat_z),
      .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_nullified(fetch_nullified),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_kind(mem_kind), .mem_nullified(mem_nullified),
      .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_emu_trap(cfg_emu_trap),
      .trap_req(trap_req), .trap_num(trap_num), .trap_addr(trap_addr)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model of the register contents
   logic [AW-1:0] m_addr [4];
   logic [AW-1:0] m_mask [4];
   logic [1:0]    m_ctrl [4];

   task automatic check(input string tag, input bit ok, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic bit hit(input int i, input logic [AW-1:0] a);
      return ((a ^ m_addr[i]) & ~m_mask[i]) == '0;
   endfunction

   task automatic wr(input int idx, input int fld, input logic [AW-1:0] data);
      cfg_valid = 1'b1; cfg_write = 1'b1;
      cfg_sel = SW'(idx * 4 + fld); cfg_wdata = data;
      #1;
      check("R4 emu flag on write", cfg_emu_trap == !unit_en, 16'(cfg_emu_trap), 16'(!unit_en));
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
      if (unit_en) begin
         if (fld == 0) m_addr[idx] = data;
         else if (fld == 1) m_mask[idx] = data;
         else if (fld == 2) m_ctrl[idx] = (idx < 2) ? {1'b0, data[0]} : data[1:0];
      end
   endtask

   task automatic rd(input string tag, input int idx, input int fld);
      logic [AW-1:0] exp;
      cfg_valid = 1'b1; cfg_write = 1'b0; cfg_sel = SW'(idx * 4 + fld);
      #1;
      if (!unit_en || fld == 3) exp = '0;
      else if (fld == 0) exp = m_addr[idx];
      else if (fld == 1) exp = m_mask[idx];
      else exp = {6'd0, m_ctrl[idx]};
      check(tag, cfg_rdata == exp, 16'(cfg_rdata), 16'(exp));
      cfg_valid = 1'b0;
      #1;
      check("R2 rdata idle zero", cfg_rdata == '0, 16'(cfg_rdata), 16'd0);
   endtask

   task automatic step(input string tag, input bit fv, input logic [AW-1:0] fa, input bit fn,
                       input bit mv, input logic [AW-1:0] ma, input logic [1:0] mk, input bit mn);
      bit ihit, dhit, ifire, dfire;
      logic [4:0] enum_exp;
      logic [AW-1:0] eaddr;
      fetch_valid = fv; fetch_addr = fa; fetch_nullified = fn;
      mem_valid = mv; mem_addr = ma; mem_kind = mk; mem_nullified = mn;
      ihit = 1'b0; dhit = 1'b0;
      for (int i = 0; i < 2; i++) if (m_ctrl[i][0] && hit(i, fa)) ihit = 1'b1;
      for (int i = 2; i < 4; i++)
         if (hit(i, ma) && ((m_ctrl[i][0] && (mk == 2'd0 || mk == 2'd2)) ||
                            (m_ctrl[i][1] && mk != 2'd0))) dhit = 1'b1;
      ifire = fv && stat_g && !stat_z && ihit;
      dfire = mv && !mn && stat_g && !stat_y && dhit;
      enum_exp = ifire ? 5'd30 : 5'd31;
      eaddr = ifire ? fa : ma;
      @(negedge clk);
      check(tag, trap_req == (ifire | dfire), 16'(trap_req), 16'(ifire | dfire));
      if (ifire | dfire)
         check(tag, trap_num == enum_exp && trap_addr == eaddr,
               {3'd0, trap_num, trap_addr}, {3'd0, enum_exp, eaddr});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_addr[i] = '0; m_mask[i] = '0; m_ctrl[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 trap_req after reset", trap_req == 1'b0, 16'(trap_req), 16'd0);
      unit_en = 1'b1;
      for (int i = 0; i < 4; i++)
         for (int f = 0; f < 4; f++) rd("R1 reset readback", i, f);

      // R2, R3: program and read back
      wr(0, 0, 8'h5A); wr(0, 1, 8'h0F); wr(0, 2, 8'hFF);
      wr(1, 0, 8'hC3); wr(1, 1, 8'h00); wr(1, 2, 8'h01);
      wr(2, 0, 8'h30); wr(2, 1, 8'h03); wr(2, 2, 8'h01);
      wr(3, 0, 8'h80); wr(3, 1, 8'h40); wr(3, 2, 8'h02);
      wr(1, 3, 8'hAA);
      for (int i = 0; i < 4; i++)
         for (int f = 0; f < 4; f++) rd("R2 R3 readback", i, f);

      // R4: unit disabled refuses the port
      unit_en = 1'b0;
      wr(0, 0, 8'hEE);
      rd("R4 read while disabled", 0, 0);
      unit_en = 1'b1;
      rd("R4 value kept after refused write", 0, 0);

      stat_g = 1'b1; stat_y = 1'b0; stat_z = 1'b0;
      // R5 R6: full fetch sweep, nullify alternates
      for (int a = 0; a < 256; a++) step("R5 R6 fetch sweep", 1, AW'(a), a[0], 0, '0, 2'd0, 0);
      // R5 R7: full data sweep per kind and nullify
      for (int k = 0; k < 4; k++)
         for (int a = 0; a < 256; a++)
            for (int n = 0; n < 2; n++)
               step("R5 R7 data sweep", 0, '0, 0, 1, AW'(a), 2'(k), n[0]);

      // R8: status gating, fetch and data together
      stat_g = 1'b0;
      for (int a = 0; a < 256; a++) step("R8 global off", 1, AW'(a), 0, 1, AW'(a ^ 8'hB0), 2'(a % 4), 0);
      stat_g = 1'b1; stat_y = 1'b1;
      for (int a = 0; a < 256; a++) step("R8 data suppressed", 1, AW'(a), 0, 1, AW'(a ^ 8'hB0), 2'(a % 4), 0);
      stat_y = 1'b0; stat_z = 1'b1;
      for (int a = 0; a < 256; a++) step("R8 instr suppressed", 1, AW'(a), 0, 1, AW'(a ^ 8'hB0), 2'(a % 4), 0);
      stat_z = 1'b0;

      // R9: same-cycle instruction and data trap
      step("R9 priority", 1, 8'h55, 0, 1, 8'h31, 2'd0, 0);
      step("R9 priority", 1, 8'hC3, 1, 1, 8'hC0, 2'd1, 0);
      step("R9 data alone", 1, 8'h00, 0, 1, 8'h32, 2'd2, 0);

      // R10: overlapping breakpoints, single pulse
      wr(1, 0, 8'h50); wr(1, 1, 8'h0F);
      wr(3, 0, 8'h30); wr(3, 1, 8'h07); wr(3, 2, 8'h03);
      step("R10 two instr hits", 1, 8'h5C, 0, 0, '0, 2'd0, 0);
      step("R10 idle after trap", 0, 8'h5C, 0, 0, '0, 2'd0, 0);
      step("R10 two data hits", 0, '0, 0, 1, 8'h31, 2'd2, 0);
      step("R10 idle after trap", 0, '0, 0, 0, 8'h31, 2'd2, 0);
      step("R10 back to back", 1, 8'h51, 0, 0, '0, 2'd0, 0);
      step("R10 back to back", 1, 8'h52, 0, 0, '0, 2'd0, 0);
      step("R10 idle", 0, '0, 0, 0, '0, 2'd0, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule